// File: doc/BRIEF.md
# Phase-staggered multicarrier PWM generator

This block drives the gates of one phase of a cascaded H-bridge stage built from `CELLS` identical cells fed by equal DC sources. A single phase counter advances by a programmable step on every enabled clock. From it the block derives `2*CELLS` triangular carriers. All carriers have the same amplitude and frequency, and they are spread evenly across one carrier period. With M = 2*CELLS+1 output levels, adjacent carriers are 360/(M-1) degrees apart: 60 degrees for three cells and 45 degrees for four. Each cell compares the signed reference against two carriers that are half a period apart. The results become that cell's two leg gates and their complements. The stacked stage output therefore steps (M-1) times per carrier period, while each device switches only at the carrier rate. Over a full period every cell conducts for the same number of cycles.

The reference sample comes from outside, and it may be a plain sine or a sine with added third harmonic; the carrier path does not depend on its shape. The block inserts no dead time and does no source balancing. A two-state controller sequences it. State PARK holds the phase at zero and all upper gates low. The transition "start" (enable high) moves it to RUN. In RUN the phase advances and compare results are registered. The transition "stop" (enable low) returns it to PARK, and reset always forces PARK.

Top module: `pscpwm_gen`

## Requirements
- R1: While reset is high (synchronous, active high), and on the first sampled outputs after it, every upper gate (`leg_a`, `leg_b`) is 0, every complement is 1 and `level` is 0.
- R2: A clock edge with `en` low leaves all upper gates 0 and the phase at 0 after that edge. After `en` rises, the first edge only enters RUN (gates still 0). The second edge registers the comparison taken at phase 0.
- R3: With MOD = 2^(REF_W+1) and phase p_k = (phase + floor(k*MOD/(2*CELLS))) mod MOD, carrier k (k = 0 .. 2*CELLS-1) equals t - 2^(REF_W-1), where t = p_k if p_k <= MOD/2 and t = MOD - p_k otherwise.
- R4: On each RUN edge with `en` high, bit i of `leg_a` becomes (ref_in > carrier i) and bit i of `leg_b` becomes (ref_in < carrier i+CELLS). Both are signed comparisons against the phase held before that edge.
- R5: `leg_a_n` is always the bitwise inverse of `leg_a`, and `leg_b_n` is always the bitwise inverse of `leg_b`.
- R6: `level` (two's complement) equals the count of ones in `leg_a` minus the count of ones in `leg_b`, and it stays within -CELLS .. +CELLS.
- R7: Each RUN edge with `en` high adds `carrier_step` to the phase modulo MOD. A step of 0 freezes the carriers, and a step of MOD-1 runs them backwards.
- R8: With a constant reference and an odd step, every cell spends the same number of cycles at output +1 (leg A high, leg B low) over MOD consecutive RUN outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run request; low parks the generator |
| ref_in | input | REF_W | Signed reference sample |
| carrier_step | input | REF_W+1 | Phase increment per clock (sets carrier period MOD/step) |
| leg_a | output | CELLS | Upper gate of leg A, one bit per cell |
| leg_a_n | output | CELLS | Complement of leg_a |
| leg_b | output | CELLS | Upper gate of leg B, one bit per cell |
| leg_b_n | output | CELLS | Complement of leg_b |
| level | output | clog2(CELLS+1)+1 | Signed sum of cell outputs |

## Verification
The hardest situation to reach is the one where the reference lies exactly on a carrier value, or at the extreme end of the carrier swing. That is where an off-by-one offset or a strict-versus-loose comparison shows up. The stimulus sweeps every reference code against a step that is coprime to the phase modulus, so each reference meets many carrier phases. It also runs full periods at step 1 for the extreme codes. Equal conduction is shown by counting each cell's +1 cycles over one whole period at an odd step. Enable toggling checks the two-edge restart from phase zero.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;
    typedef enum logic {
        ST_PARK = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_t;
endpackage

// File: rtl/pscpwm_seq.sv
module pscpwm_seq
    import pscpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic advance,
    output logic clear
);
    pwm_state_t st_q;
    pwm_state_t st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_PARK;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PARK: if (en)  st_d = ST_RUN;
            ST_RUN:  if (!en) st_d = ST_PARK;
            default: st_d = ST_PARK;
        endcase
    end

    always_comb begin
        advance = 1'b0;
        clear   = 1'b1;
        unique case (st_q)
            ST_PARK: begin
                advance = 1'b0;
                clear   = 1'b1;
            end
            ST_RUN: begin
                advance = en;
                clear   = !en;
            end
            default: begin
                advance = 1'b0;
                clear   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pscpwm_phase.sv
module pscpwm_phase #(
    parameter int PH_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            clear,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || clear) phase <= '0;
        else if (advance) phase <= phase + step;
    end
endmodule

// File: rtl/pscpwm_carrier.sv
module pscpwm_carrier #(
    parameter int REF_W  = 8,
    parameter int OFFSET = 0
) (
    input  logic        [REF_W:0] phase,
    output logic signed [REF_W:0] carrier
);
    localparam int PH_W = REF_W + 1;
    localparam logic [PH_W-1:0] OFF_V = PH_W'(OFFSET);
    localparam logic signed [PH_W:0] MID = (PH_W+1)'(1 << (REF_W - 1));

    logic        [PH_W-1:0] shifted;
    logic        [PH_W-1:0] folded;
    logic signed [PH_W:0]   wide;

    always_comb begin
        shifted = phase + OFF_V;
        // upper half of the phase circle counts back down
        folded  = shifted[PH_W-1] ? (~shifted + 1'b1) : shifted;
        wide    = $signed({1'b0, folded}) - MID;
        carrier = wide[PH_W-1:0];
    end
endmodule

// File: rtl/pscpwm_cell.sv
module pscpwm_cell #(
    parameter int REF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic signed [REF_W:0]   car_a,
    input  logic signed [REF_W:0]   car_b,
    output logic                nxt_a,
    output logic                nxt_b,
    output logic                gate_a,
    output logic                gate_b
);
    logic signed [REF_W:0] ref_x;

    always_comb begin
        ref_x = {ref_in[REF_W-1], ref_in};
        nxt_a = !clear && (ref_x > car_a);
        nxt_b = !clear && (ref_x < car_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_a <= 1'b0;
            gate_b <= 1'b0;
        end else begin
            gate_a <= nxt_a;
            gate_b <= nxt_b;
        end
    end
endmodule

// File: rtl/pscpwm_gen.sv
module pscpwm_gen #(
    parameter int CELLS = 3,
    parameter int REF_W = 8,
    localparam int PH_W  = REF_W + 1,
    localparam int LVL_W = $clog2(CELLS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic [PH_W-1:0]         carrier_step,
    output logic [CELLS-1:0]        leg_a,
    output logic [CELLS-1:0]        leg_a_n,
    output logic [CELLS-1:0]        leg_b,
    output logic [CELLS-1:0]        leg_b_n,
    output logic signed [LVL_W-1:0] level
);
    localparam int NCAR = 2 * CELLS;
    localparam int MOD  = 1 << PH_W;
    localparam logic signed [LVL_W-1:0] ONE = LVL_W'(1);

    logic                   advance;
    logic                   clear;
    logic [PH_W-1:0]        phase;
    logic signed [PH_W-1:0] car [NCAR];
    logic [CELLS-1:0]       nxt_a;
    logic [CELLS-1:0]       nxt_b;
    logic signed [LVL_W-1:0] lvl_d;

    pscpwm_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .advance (advance),
        .clear   (clear)
    );

    pscpwm_phase #(.PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .clear   (clear),
        .step    (carrier_step),
        .phase   (phase)
    );

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        pscpwm_carrier #(
            .REF_W  (REF_W),
            .OFFSET ((k * MOD) / NCAR)
        ) u_car (
            .phase   (phase),
            .carrier (car[k])
        );
    end

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        pscpwm_cell #(.REF_W(REF_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .clear  (clear),
            .ref_in (ref_in),
            .car_a  (car[i]),
            .car_b  (car[i + CELLS]),
            .nxt_a  (nxt_a[i]),
            .nxt_b  (nxt_b[i]),
            .gate_a (leg_a[i]),
            .gate_b (leg_b[i])
        );
    end

    always_comb begin
        lvl_d = '0;
        for (int i = 0; i < CELLS; i++) begin
            if (nxt_a[i]) lvl_d = lvl_d + ONE;
            if (nxt_b[i]) lvl_d = lvl_d - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= lvl_d;
    end

    assign leg_a_n = ~leg_a;
    assign leg_b_n = ~leg_b;
endmodule

// File: rtl/pscpwm_gen_chk.sv
module pscpwm_gen_chk #(
    parameter int CELLS = 3,
    parameter int LVL_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [CELLS-1:0]        leg_a,
    input logic [CELLS-1:0]        leg_a_n,
    input logic [CELLS-1:0]        leg_b,
    input logic [CELLS-1:0]        leg_b_n,
    input logic signed [LVL_W-1:0] level
);
    a_r5_complement: assert property (@(posedge clk) disable iff (rst)
        (leg_a_n == ~leg_a) && (leg_b_n == ~leg_b));

    a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(level) <= CELLS) && (int'(level) >= -CELLS));

    a_r6_level_matches_gates: assert property (@(posedge clk) disable iff (rst)
        int'(level) == ($countones(leg_a) - $countones(leg_b)));

    a_r2_parked_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (leg_a == '0) && (leg_b == '0));

    a_r2_start_edge_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> (leg_a == '0) && (leg_b == '0));
endmodule

bind pscpwm_gen pscpwm_gen_chk #(.CELLS(CELLS), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .leg_a   (leg_a),
    .leg_a_n (leg_a_n),
    .leg_b   (leg_b),
    .leg_b_n (leg_b_n),
    .level   (level)
);

// File: tb/pscpwm_gen_test.sv
module pscpwm_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 3;
    localparam int REF_W = 8;
    localparam int PH_W  = REF_W + 1;
    localparam int MOD   = 1 << PH_W;
    localparam int NCAR  = 2 * CELLS;
    localparam int LVL_W = $clog2(CELLS + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [REF_W-1:0] ref_in = '0;
    logic [PH_W-1:0] carrier_step = '0;
    logic [CELLS-1:0] leg_a, leg_a_n, leg_b, leg_b_n;
    logic signed [LVL_W-1:0] level;

    pscpwm_gen #(.CELLS(CELLS), .REF_W(REF_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .ref_in       (ref_in),
        .carrier_step (carrier_step),
        .leg_a        (leg_a),
        .leg_a_n      (leg_a_n),
        .leg_b        (leg_b),
        .leg_b_n      (leg_b_n),
        .level        (level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int m_ph = 0;
    bit m_run = 0;
    bit armed = 0;
    bit counting = 0;
    logic [CELLS-1:0] ea = '0;
    logic [CELLS-1:0] eb = '0;
    int elev = 0;
    int cnt [CELLS];

    function automatic int car(int ph, int k);
        int p, t;
        p = (ph + (k * MOD) / NCAR) % MOD;
        t = (p <= MOD/2) ? p : MOD - p;
        return t - MOD/4;
    endfunction

    task automatic check_outs(string tag);
        total++;
        if (leg_a !== ea || leg_b !== eb) begin
            bad++;
            $display("FAIL %s gates: a=%b b=%b expected a=%b b=%b", tag, leg_a, leg_b, ea, eb);
        end
        total++;
        if (leg_a_n !== ~ea || leg_b_n !== ~eb) begin
            bad++;
            $display("FAIL R5 complements: an=%b bn=%b expected an=%b bn=%b", leg_a_n, leg_b_n, ~ea, ~eb);
        end
        total++;
        if (int'(level) != elev || elev > CELLS || elev < -CELLS) begin
            bad++;
            $display("FAIL R6 level: got %0d expected %0d", int'(level), elev);
        end
    endtask

    task automatic cyc(bit r, bit e, int rv, int sv, string tag);
        @(negedge clk);
        if (armed) check_outs(tag);
        if (counting) begin
            for (int i = 0; i < CELLS; i++)
                if (leg_a[i] && !leg_b[i]) cnt[i]++;
        end
        rst = r;
        en = e;
        ref_in = REF_W'(rv);
        carrier_step = PH_W'(sv);
        if (r) begin
            m_run = 0; m_ph = 0; ea = '0; eb = '0; elev = 0;
        end else if (m_run && e) begin
            elev = 0;
            for (int i = 0; i < CELLS; i++) begin
                ea[i] = (rv > car(m_ph, i));
                eb[i] = (rv < car(m_ph, i + CELLS));
                elev += int'(ea[i]) - int'(eb[i]);
            end
            m_ph = (m_ph + sv) % MOD;
        end else begin
            ea = '0; eb = '0; elev = 0; m_ph = 0;
            m_run = e;
        end
        armed = 1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < CELLS; i++) cnt[i] = 0;
        // R1: reset state
        for (int n = 0; n < 4; n++) cyc(1, 1, 50, 3, "R1");
        for (int n = 0; n < 3; n++) cyc(0, 0, 50, 3, "R1");

        // R4: every reference code against a coprime step
        for (int rv = -(1 << (REF_W-1)); rv < (1 << (REF_W-1)); rv++)
            for (int n = 0; n < 20; n++) cyc(0, 1, rv, 37, "R4");

        // R3: full periods at unit step, extremes and middle
        begin
            int refs [5] = '{0, 100, -100, 127, -128};
            foreach (refs[j])
                for (int n = 0; n < MOD + 8; n++) cyc(0, 1, refs[j], 1, "R3");
        end

        // R7: frozen, large and backwards steps
        for (int n = 0; n < 40; n++) cyc(0, 1, (n * 13) % 200 - 100, 0, "R7");
        for (int n = 0; n < 60; n++) cyc(0, 1, 20 - n, 255, "R7");
        for (int n = 0; n < 60; n++) cyc(0, 1, n - 30, MOD - 1, "R7");

        // R2: enable toggling restarts from phase zero
        for (int rep = 0; rep < 6; rep++) begin
            for (int n = 0; n < 7; n++) cyc(0, 1, 40 - rep * 15, 11, "R2");
            for (int n = 0; n < 3; n++) cyc(0, 0, 40 - rep * 15, 11, "R2");
        end
        for (int rep = 0; rep < 4; rep++) begin
            cyc(0, 1, 10, 7, "R2");
            cyc(0, 0, 10, 7, "R2");
        end

        // R1: reset in the middle of running
        for (int n = 0; n < 10; n++) cyc(0, 1, 60, 9, "R1");
        cyc(1, 1, 60, 9, "R1");
        cyc(0, 1, 60, 9, "R1");
        cyc(0, 1, 60, 9, "R1");

        // R8: equal conduction over one period at an odd step
        begin
            int refs8 [3] = '{30, -70, 0};
            foreach (refs8[j]) begin
                cyc(0, 0, refs8[j], 5, "R8");
                cyc(0, 0, refs8[j], 5, "R8");
                cyc(0, 1, refs8[j], 5, "R8");
                cyc(0, 1, refs8[j], 5, "R8");
                for (int i = 0; i < CELLS; i++) cnt[i] = 0;
                counting = 1;
                for (int n = 0; n < MOD; n++) cyc(0, 1, refs8[j], 5, "R8");
                counting = 0;
                for (int i = 1; i < CELLS; i++) begin
                    total++;
                    if (cnt[i] != cnt[0]) begin
                        bad++;
                        $display("FAIL R8 cell %0d on-count: got %0d expected %0d", i, cnt[i], cnt[0]);
                    end
                end
            end
        end

        cyc(0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, "R2");
        finish_run();
    end
endmodule